// File: doc/BRIEF.md
# Logic Analyzer Sample Capture Buffer

This block records a probe bus into an on-chip sample memory whenever a capture qualifier is high. The moment that gets recorded can be moved by one clock either way from the qualifier: the value from the cycle before, the same cycle, or the cycle after. With change-only capture turned on, a qualified sample is dropped when it matches the last value stored. This keeps long runs of a quiet bus out of the memory.

The memory fills in one of two ways. In linear mode it stops at the last entry, and the status output reports how many samples it holds. In circular mode it wraps and overwrites the oldest entries, and the status output gives the index of the most recent write. An optional free-running cycle counter can be stored next to each probe value, so the time between samples can be recovered. Software reads any entry by presenting an index on a registered read port.

Top module: `lacap_buffer`

## Requirements
- R1: After reset `level_o` is 0, and the first qualified sample after reset is always stored, even in change-only mode when the probe is 0.
- R2: With `ofs_i` = 2'b00, or the reserved code 2'b11, a high `qual_i` at a clock edge stores the `probe_i` value present at that same edge.
- R3: With `ofs_i` = 2'b10 (minus one), a high `qual_i` at an edge stores the `probe_i` value sampled at the previous edge.
- R4: With `ofs_i` = 2'b01 (plus one), a high `qual_i` at an edge causes a store at the following edge of the `probe_i` value present there.
- R5: While the qualifier stays low, nothing is stored and `level_o` does not change.
- R6: With `dedup_i` = 1, a qualified sample equal to the last stored probe value is skipped and a different one is stored. With `dedup_i` = 0, equal samples are all stored.
- R7: With `wrap_i` = 0 (linear), `level_o` is the number of stored samples. It saturates at 2^ADDR_W, and once the buffer is full no entry is overwritten.
- R8: With `wrap_i` = 1 (circular), `level_o` is the index of the last entry written. Writes go to indices 0, 1, ... and wrap from 2^ADDR_W-1 back to 0, overwriting older entries.
- R9: `rd_data_o` shows the entry at `rd_addr_i` one clock edge after the address is presented. The probe value sits in the top SMP_W bits, and when stamping is on the cycle counter sits in the low STAMP_W bits.
- R10: With STAMP_EN = 1, the stamps of two entries written N clock edges apart differ by N modulo 2^STAMP_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_i | input | SMP_W | Probe bus being recorded |
| qual_i | input | 1 | Capture qualifier |
| ofs_i | input | 2 | Capture offset: 00 same, 01 plus one, 10 minus one, 11 same |
| dedup_i | input | 1 | Change-only capture enable |
| wrap_i | input | 1 | 1 selects circular fill, 0 selects linear fill |
| rd_addr_i | input | ADDR_W | Read index |
| rd_data_o | output | SMP_W+STAMP_W (STAMP_W only when STAMP_EN=1) | Registered entry at the read index |
| level_o | output | ADDR_W+1 | Sample count (linear) or last written index (circular) |

## Verification
The capture path is driven with a probe that changes every cycle. Under each offset code this makes it clear which of three neighbouring probe values got stored. Runs of repeated values, run with change-only capture on and then off, separate skipped duplicates from stored ones, and a repeated zero right after reset shows that the last-value register starts out empty. Filling past the depth in both fill modes shows linear saturation apart from circular overwrite and index wrap. Entries written a known number of cycles apart check the stamp spacing.

// File: rtl/lacap_pkg.sv
package lacap_pkg;

   typedef enum logic [1:0] {
      OFS_SAME = 2'b00,
      OFS_NEXT = 2'b01,
      OFS_PREV = 2'b10,
      OFS_RSVD = 2'b11
   } ofs_e;

   function automatic int entry_width(input int smp_w, input bit stamp_en, input int stamp_w);
      return smp_w + (stamp_en ? stamp_w : 0);
   endfunction

endpackage

// File: rtl/lacap_align.sv
// Picks the probe value and the write strobe according to the capture offset.
module lacap_align
   import lacap_pkg::*;
#(
   parameter int SMP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SMP_W-1:0] probe_i,
   input  logic             qual_i,
   input  logic [1:0]       ofs_i,
   output logic             cand_vld_o,
   output logic [SMP_W-1:0] cand_o
);

   logic [SMP_W-1:0] probe_q;
   logic             qual_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         probe_q <= '0;
         qual_q  <= 1'b0;
      end else begin
         probe_q <= probe_i;
         qual_q  <= qual_i;
      end
   end

   always_comb begin
      cand_vld_o = qual_i;
      cand_o     = probe_i;
      case (ofs_e'(ofs_i))
         OFS_NEXT: begin
            cand_vld_o = qual_q;
            cand_o     = probe_i;
         end
         OFS_PREV: begin
            cand_vld_o = qual_i;
            cand_o     = probe_q;
         end
         default: begin
            cand_vld_o = qual_i;
            cand_o     = probe_i;
         end
      endcase
   end

endmodule

// File: rtl/lacap_stamp.sv
// Free-running cycle counter used as a time stamp.
module lacap_stamp #(
   parameter int STAMP_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [STAMP_W-1:0] cnt_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_o <= '0;
      else        cnt_o <= cnt_o + 1'b1;
   end

endmodule

// File: rtl/lacap_store.sv
// Sample memory with write pointer, fill status and change-only filter.
module lacap_store #(
   parameter int SMP_W   = 8,
   parameter int ENTRY_W = 16,
   parameter int ADDR_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cand_vld_i,
   input  logic [SMP_W-1:0]   cand_probe_i,
   input  logic [ENTRY_W-1:0] cand_entry_i,
   input  logic               dedup_i,
   input  logic               wrap_i,
   input  logic [ADDR_W-1:0]  rd_addr_i,
   output logic [ENTRY_W-1:0] rd_data_o,
   output logic [ADDR_W:0]    level_o,
   output logic               wr_en_o,
   output logic [ADDR_W-1:0]  wr_idx_o
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam int LVL_W = ADDR_W + 1;
   localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

   logic [ENTRY_W-1:0] mem_q [DEPTH];
   logic [ADDR_W-1:0]  wptr_q;
   logic [ADDR_W-1:0]  last_idx_q;
   logic [LVL_W-1:0]   cnt_q;
   logic [SMP_W-1:0]   last_q;
   logic               last_vld_q;
   logic               full;
   logic               dup;

   assign full     = !wrap_i && (cnt_q == DEPTH_L);
   assign dup      = dedup_i && last_vld_q && (cand_probe_i == last_q);
   assign wr_en_o  = cand_vld_i && !dup && !full;
   assign wr_idx_o = wptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q     <= '0;
         last_idx_q <= '0;
         cnt_q      <= '0;
         last_q     <= '0;
         last_vld_q <= 1'b0;
      end else if (wr_en_o) begin
         wptr_q     <= wptr_q + 1'b1;
         last_idx_q <= wptr_q;
         cnt_q      <= (cnt_q == DEPTH_L) ? cnt_q : cnt_q + 1'b1;
         last_q     <= cand_probe_i;
         last_vld_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en_o) mem_q[wptr_q] <= cand_entry_i;
   end

   always_ff @(posedge clk) begin
      rd_data_o <= mem_q[rd_addr_i];
   end

   assign level_o = wrap_i ? {1'b0, last_idx_q} : cnt_q;

endmodule

// File: rtl/lacap_buffer.sv
// Top level: offset alignment, optional stamping and sample storage.
module lacap_buffer
   import lacap_pkg::*;
#(
   parameter int SMP_W    = 8,
   parameter int ADDR_W   = 4,
   parameter bit STAMP_EN = 1'b1,
   parameter int STAMP_W  = 8,
   localparam int ENTRY_W = entry_width(SMP_W, STAMP_EN, STAMP_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SMP_W-1:0]   probe_i,
   input  logic               qual_i,
   input  logic [1:0]         ofs_i,
   input  logic               dedup_i,
   input  logic               wrap_i,
   input  logic [ADDR_W-1:0]  rd_addr_i,
   output logic [ENTRY_W-1:0] rd_data_o,
   output logic [ADDR_W:0]    level_o
);

   if (SMP_W < 1) begin : g_bad_smp
      $error("lacap_buffer: SMP_W must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("lacap_buffer: ADDR_W must be in 1..12");
   end
   if (STAMP_EN && STAMP_W < 1) begin : g_bad_stamp
      $error("lacap_buffer: STAMP_W must be at least 1 when stamping");
   end

   logic               cand_vld;
   logic [SMP_W-1:0]   cand;
   logic [ENTRY_W-1:0] entry;
   logic               wr_en;
   logic [ADDR_W-1:0]  wr_idx;

   lacap_align #(.SMP_W(SMP_W)) u_align (
      .clk        (clk),
      .rst_n      (rst_n),
      .probe_i    (probe_i),
      .qual_i     (qual_i),
      .ofs_i      (ofs_i),
      .cand_vld_o (cand_vld),
      .cand_o     (cand)
   );

   if (STAMP_EN) begin : g_stamp
      logic [STAMP_W-1:0] stamp;
      lacap_stamp #(.STAMP_W(STAMP_W)) u_stamp (
         .clk   (clk),
         .rst_n (rst_n),
         .cnt_o (stamp)
      );
      assign entry = {cand, stamp};
   end else begin : g_plain
      assign entry = cand;
   end

   lacap_store #(
      .SMP_W   (SMP_W),
      .ENTRY_W (ENTRY_W),
      .ADDR_W  (ADDR_W)
   ) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .cand_vld_i   (cand_vld),
      .cand_probe_i (cand),
      .cand_entry_i (entry),
      .dedup_i      (dedup_i),
      .wrap_i       (wrap_i),
      .rd_addr_i    (rd_addr_i),
      .rd_data_o    (rd_data_o),
      .level_o      (level_o),
      .wr_en_o      (wr_en),
      .wr_idx_o     (wr_idx)
   );

endmodule

// File: rtl/lacap_checker.sv
module lacap_checker #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              qual_i,
   input logic [1:0]        ofs_i,
   input logic              wrap_i,
   input logic [ADDR_W:0]   level_o,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_idx
);

   localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W+1)'(1 << ADDR_W);

   // R2 / R5: with same-cycle capture, no write happens without the qualifier
   p_same_needs_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ofs_i == 2'b00 && !qual_i) |-> !wr_en);

   // R4: a plus-one write follows a qualifier at the previous edge
   p_next_follows_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ofs_i == 2'b01 && $past(ofs_i) == 2'b01 && wr_en) |-> $past(qual_i));

   // R7: the linear count never exceeds the depth
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_i |-> (level_o <= DEPTH_L));

   // R7: a full linear buffer stays full
   p_full_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wrap_i && level_o == DEPTH_L) |=> (wrap_i || level_o == DEPTH_L));

   // R8: in circular mode the status shows the index just written
   p_last_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_i && wr_en) |=> (!wrap_i || level_o == {1'b0, $past(wr_idx)}));

endmodule

bind lacap_buffer lacap_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .qual_i  (qual_i),
   .ofs_i   (ofs_i),
   .wrap_i  (wrap_i),
   .level_o (level_o),
   .wr_en   (wr_en),
   .wr_idx  (wr_idx)
);

// File: tb/lacap_buffer_test.sv
module lacap_buffer_test;

   localparam int SMP_W   = 8;
   localparam int ADDR_W  = 4;
   localparam int STAMP_W = 8;
   localparam int DEPTH   = 1 << ADDR_W;
   localparam int ENTRY_W = SMP_W + STAMP_W;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [SMP_W-1:0]   probe = '0;
   logic               qual = 1'b0;
   logic [1:0]         ofs = 2'b00;
   logic               dedup = 1'b0;
   logic               wrap = 1'b0;
   logic [ADDR_W-1:0]  rd_addr = '0;
   logic [ENTRY_W-1:0] rd_data;
   logic [ADDR_W:0]    level;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   lacap_buffer #(
      .SMP_W(SMP_W), .ADDR_W(ADDR_W), .STAMP_EN(1'b1), .STAMP_W(STAMP_W)
   ) uut (
      .clk(clk), .rst_n(rst_n), .probe_i(probe), .qual_i(qual), .ofs_i(ofs),
      .dedup_i(dedup), .wrap_i(wrap), .rd_addr_i(rd_addr),
      .rd_data_o(rd_data), .level_o(level)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] o, input logic d, input logic w);
      @(negedge clk);
      rst_n = 1'b0; qual = 1'b0; probe = '0; ofs = o; dedup = d; wrap = w;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one qualified cycle at the current negedge, then qualifier low
   task automatic cap(input logic [SMP_W-1:0] v);
      probe = v; qual = 1'b1;
      @(negedge clk);
      qual = 1'b0;
   endtask

   task automatic rd(input int idx, output logic [ENTRY_W-1:0] d);
      rd_addr = ADDR_W'(idx);
      @(negedge clk);
      d = rd_data;
   endtask

   task automatic t_reset_and_same;
      logic [ENTRY_W-1:0] d;
      do_reset(2'b00, 1'b0, 1'b0);
      check("R1 level after reset", int'(level), 0);
      cap(8'h3C);
      check("R2 level after one capture", int'(level), 1);
      rd(0, d);
      check("R2 same-cycle value", int'(d[ENTRY_W-1 -: SMP_W]), 'h3C);
      ofs = 2'b11;
      cap(8'h5A);
      rd(1, d);
      check("R2 reserved code acts as same", int'(d[ENTRY_W-1 -: SMP_W]), 'h5A);
   endtask

   task automatic t_prev;
      logic [ENTRY_W-1:0] d;
      do_reset(2'b10, 1'b0, 1'b0);
      probe = 8'h11;
      @(negedge clk);
      cap(8'h22);
      rd(0, d);
      check("R3 minus-one value", int'(d[ENTRY_W-1 -: SMP_W]), 'h11);
   endtask

   task automatic t_next;
      logic [ENTRY_W-1:0] d;
      do_reset(2'b01, 1'b0, 1'b0);
      probe = 8'h44; qual = 1'b1;
      @(negedge clk);
      qual = 1'b0; probe = 8'h55;
      @(negedge clk);
      probe = 8'h66;
      check("R4 level after delayed store", int'(level), 1);
      rd(0, d);
      check("R4 plus-one value", int'(d[ENTRY_W-1 -: SMP_W]), 'h55);
   endtask

   task automatic t_idle;
      do_reset(2'b00, 1'b0, 1'b0);
      cap(8'h01);
      for (int i = 0; i < 6; i++) begin
         probe = 8'(i + 9);
         @(negedge clk);
      end
      check("R5 level unchanged without qualifier", int'(level), 1);
   endtask

   task automatic t_dedup;
      logic [ENTRY_W-1:0] d;
      do_reset(2'b00, 1'b1, 1'b0);
      cap(8'h00);
      check("R1 first zero stored in change-only", int'(level), 1);
      cap(8'h00); cap(8'h00);
      check("R6 repeats skipped", int'(level), 1);
      cap(8'h07); cap(8'h07); cap(8'h00);
      check("R6 differing values stored", int'(level), 3);
      rd(2, d);
      check("R6 third entry", int'(d[ENTRY_W-1 -: SMP_W]), 0);
      dedup = 1'b0;
      cap(8'h00); cap(8'h00);
      check("R6 repeats stored when off", int'(level), 5);
   endtask

   task automatic t_linear_full;
      logic [ENTRY_W-1:0] d;
      do_reset(2'b00, 1'b0, 1'b0);
      for (int i = 0; i < DEPTH + 4; i++) cap(8'(i + 100));
      check("R7 level saturates", int'(level), DEPTH);
      rd(0, d);
      check("R7 entry 0 kept", int'(d[ENTRY_W-1 -: SMP_W]), 100);
      rd(DEPTH - 1, d);
      check("R9 last entry readback", int'(d[ENTRY_W-1 -: SMP_W]), 100 + DEPTH - 1);
   endtask

   task automatic t_circular;
      logic [ENTRY_W-1:0] d;
      do_reset(2'b00, 1'b0, 1'b1);
      cap(8'd0);
      check("R8 index after first write", int'(level), 0);
      for (int i = 1; i < 5; i++) cap(8'(i));
      check("R8 index after five writes", int'(level), 4);
      for (int i = 5; i < DEPTH + 2; i++) cap(8'(i));
      check("R8 index after wrap", int'(level), 1);
      rd(0, d);
      check("R8 entry 0 overwritten", int'(d[ENTRY_W-1 -: SMP_W]), DEPTH);
      rd(2, d);
      check("R8 entry 2 kept", int'(d[ENTRY_W-1 -: SMP_W]), 2);
   endtask

   task automatic t_stamp;
      logic [ENTRY_W-1:0] a;
      logic [ENTRY_W-1:0] b;
      do_reset(2'b00, 1'b0, 1'b0);
      cap(8'h10);
      @(negedge clk);
      @(negedge clk);
      cap(8'h20);
      rd(0, a);
      rd(1, b);
      check("R10 stamp spacing", int'(8'(b[STAMP_W-1:0] - a[STAMP_W-1:0])), 3);
      rd_addr = '0;
      @(negedge clk);
      rd_addr = 4'd1;
      check("R9 data before edge still old", int'(rd_data[ENTRY_W-1 -: SMP_W]), 'h10);
      @(negedge clk);
      check("R9 data one edge later", int'(rd_data[ENTRY_W-1 -: SMP_W]), 'h20);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      t_reset_and_same();
      t_prev();
      t_next();
      t_idle();
      t_dedup();
      t_linear_full();
      t_circular();
      t_stamp();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule